// File: doc/BRIEF.md
# 36-bit Floating Adder with Optional Rounding

This block adds or subtracts two single-precision floating words held in a 36-bit format. Bit 35 is the sign, bits 34:27 hold an 8-bit exponent biased by 128, and bits 26:0 hold a 27-bit fraction whose leading bit has weight one half. A negative number is the two's complement of the whole 36-bit word. When such a word is taken apart, its exponent field is read back through a ones' complement.

Each request is marked by a valid strobe. The block unpacks both operands into a 64-bit working fraction. This fraction has a carry position at the top, the fraction field below it, and 36 low positions underneath. The operand with the smaller exponent is shifted right into alignment. The two fractions are then summed, the result is normalized, optionally rounded and repacked. The packed result and the range flags are registered and appear one clock after the request.

Top module: `fa36_adder`

## Requirements
- R1: A word with bit 35 set is treated as negative. Its exponent is the ones' complement of bits 34:27. The packed result of a negative value is the 36-bit two's complement of the positive packing `{0, exp[7:0], frac[26:0]}`.
- R2: When `sub_i` is 1, the 36-bit two's complement of `b_i` is used in place of `b_i` before any other step.
- R3: If `a_i` is zero, the result is the effective second operand, normalized, rounded if asked, and packed. If the effective second operand is zero, the result is `a_i` taken through the same path.
- R4: A negative word whose fraction field is zero unpacks as a normalized fraction of minus one half times two, with the exponent raised by one. For example, `36'hBF8000000` yields `36'hBF4000000` (-1.0).
- R5: The operand with the smaller exponent is shifted right arithmetically by the exponent difference. The shift amount saturates at 63.
- R6: With unlike signs, a negative sum is negated and the result is marked negative; otherwise the result is positive. With like signs, a carry out of the sum shifts the fraction right by one and adds one to the exponent.
- R7: A nonzero result is shifted left until its leading fraction bit is 1, and the exponent drops by the shift count. A zero fraction gives the all-zero word with no flags.
- R8: When `rnd_i` is 1, one is added at the bit just below the 27-bit fraction. A carry out of that addition shifts the fraction right by one and raises the exponent by one.
- R9: A final exponent below 0 sets `ovf_o`, `fov_o`, `unf_o` and `trap_o`. The exponent field then holds the low 8 bits of the exponent.
- R10: A final exponent above 255 sets `ovf_o`, `fov_o` and `trap_o`, and leaves `unf_o` clear. The exponent field holds the low 8 bits.
- R11: Results and flags appear one clock after a cycle with `vld_i` high, and `vld_o` is high for that one cycle. In cycles with `vld_i` low, `res_o` and the flags hold their values.
- R12: Synchronous reset clears `res_o`, all flags and `vld_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vld_i | input | 1 | Request strobe |
| a_i | input | 36 | First operand word |
| b_i | input | 36 | Second operand word |
| sub_i | input | 1 | 1 selects a minus b |
| rnd_i | input | 1 | 1 enables rounding |
| res_o | output | 36 | Packed result word |
| ovf_o | output | 1 | Arithmetic overflow (any exponent out of range) |
| fov_o | output | 1 | Floating overflow (any exponent out of range) |
| unf_o | output | 1 | Floating underflow (exponent below zero) |
| trap_o | output | 1 | Trap request (any exponent out of range) |
| vld_o | output | 1 | Result valid, one clock after request |

## Verification
The bench builds the block with its default widths: an 8-bit exponent, a 27-bit fraction and 36 low working bits. These give a 64-bit working fraction. With these values, exponent differences of up to 255 can drive the 63-place shift cap, and fully unnormalized operands can push the exponent well below zero. A fraction of all ones can carry out during rounding. Random operands drawn from narrow and full exponent ranges, in both signs, exercise the cancellation and like-sign carry paths. Hand-worked words cover the negative zero-fraction unpack, the saturated shift, the rounding carry, and both exponent range faults.

// File: rtl/fa36_pkg.sv
package fa36_pkg;
  parameter int EXP_W  = 8;
  parameter int FRAC_W = 27;
  parameter int LOW_W  = 36;

  localparam int WORD_W  = 1 + EXP_W + FRAC_W;
  localparam int UF_W    = 1 + FRAC_W + LOW_W;
  localparam int XW      = EXP_W + 4;
  localparam int SH_W    = $clog2(UF_W);
  localparam int CRY_B   = UF_W - 1;
  localparam int NRM_B   = UF_W - 2;
  localparam int RND_B   = LOW_W - 1;
  localparam int EXP_MAX = (1 << EXP_W) - 1;

  // working form: sign, wide signed exponent, fraction with carry on top
  typedef struct packed {
    logic                 sgn;
    logic signed [XW-1:0] exp;
    logic [UF_W-1:0]      frac;
  } ufp_t;
endpackage

// File: rtl/fa36_unpack.sv
module fa36_unpack import fa36_pkg::*; #(
  parameter bit SIGNED_FRAC = 1'b0
) (
  input  logic [WORD_W-1:0] word_i,
  output ufp_t              uf_o
);
  logic                 neg;
  logic [EXP_W-1:0]     efld;
  logic [UF_W-1:0]      raw;
  logic signed [XW-1:0] ebase;

  assign neg   = word_i[WORD_W-1];
  assign efld  = neg ? ~word_i[WORD_W-2 -: EXP_W] : word_i[WORD_W-2 -: EXP_W];
  assign raw   = {1'b0, word_i[FRAC_W-1:0], {LOW_W{1'b0}}};
  assign ebase = $signed({{(XW-EXP_W){1'b0}}, efld});

  generate
    if (SIGNED_FRAC) begin : g_twos
      // fraction kept in two's complement, sign copied into carry slot
      always_comb begin
        uf_o.sgn  = neg;
        uf_o.exp  = ebase;
        uf_o.frac = raw;
        if (neg) begin
          if (raw != '0) begin
            uf_o.frac[CRY_B] = 1'b1;
          end else begin
            uf_o.exp         = ebase + $signed(XW'(1));
            uf_o.frac        = '0;
            uf_o.frac[CRY_B] = 1'b1;
            uf_o.frac[NRM_B] = 1'b1;
          end
        end
      end
    end else begin : g_mag
      // fraction reduced to its magnitude
      always_comb begin
        uf_o.sgn  = neg;
        uf_o.exp  = ebase;
        uf_o.frac = raw;
        if (neg) begin
          if (raw != '0) begin
            uf_o.frac        = -raw;
            uf_o.frac[CRY_B] = 1'b0;
          end else begin
            uf_o.exp         = ebase + $signed(XW'(1));
            uf_o.frac        = '0;
            uf_o.frac[NRM_B] = 1'b1;
          end
        end
      end
    end
  endgenerate
endmodule

// File: rtl/fa36_align_add.sv
module fa36_align_add import fa36_pkg::*; (
  input  ufp_t ua_i,
  input  ufp_t ub_i,
  output ufp_t sum_o
);
  ufp_t            big;
  ufp_t            sml;
  logic [XW-1:0]   diff;
  logic [SH_W-1:0] sh;
  logic [UF_W-1:0] shifted;
  logic [UF_W-1:0] tot;
  logic [UF_W-1:0] mag;

  always_comb begin
    if (ub_i.exp > ua_i.exp) begin
      big = ub_i;
      sml = ua_i;
    end else begin
      big = ua_i;
      sml = ub_i;
    end
    diff = big.exp - sml.exp;
    if (diff > XW'(CRY_B)) sh = SH_W'(CRY_B);
    else                   sh = diff[SH_W-1:0];
    shifted = $signed(sml.frac) >>> sh;
    tot     = big.frac + shifted;
    mag     = '0;
    sum_o.exp = big.exp;
    if (big.sgn != sml.sgn) begin
      sum_o.sgn  = tot[CRY_B];
      sum_o.frac = tot[CRY_B] ? -tot : tot;
    end else begin
      sum_o.sgn = big.sgn;
      mag       = big.sgn ? -tot : tot;
      if (mag[CRY_B]) begin
        sum_o.frac = mag >> 1;
        sum_o.exp  = big.exp + $signed(XW'(1));
      end else begin
        sum_o.frac = mag;
      end
    end
  end
endmodule

// File: rtl/fa36_norm_round.sv
module fa36_norm_round import fa36_pkg::*; (
  input  ufp_t x_i,
  input  logic rnd_i,
  output ufp_t y_o
);
  logic [UF_W-1:0]      f0, f1, f2;
  logic signed [XW-1:0] e0, e1, e2;
  logic [SH_W-1:0]      lead, lz;

  always_comb begin
    f0 = x_i.frac;
    e0 = x_i.exp;
    if (x_i.frac[CRY_B]) begin
      f0 = x_i.frac >> 1;
      e0 = x_i.exp + $signed(XW'(1));
    end
    // position of the highest set bit below the carry slot
    lead = '0;
    for (int i = 0; i < CRY_B; i++) begin
      if (f0[i]) lead = SH_W'(i);
    end
    lz = SH_W'(NRM_B) - lead;
    f1 = f0 << lz;
    e1 = e0 - $signed(XW'(lz));
    f2 = f1;
    e2 = e1;
    if (rnd_i) begin
      f2 = f1 + (UF_W'(1) << RND_B);
      if (f2[CRY_B]) begin
        f2 = f2 >> 1;
        e2 = e1 + $signed(XW'(1));
      end
    end
    if (f0 == '0) begin
      y_o = '0;
    end else begin
      y_o.sgn  = x_i.sgn;
      y_o.exp  = e2;
      y_o.frac = f2;
    end
  end
endmodule

// File: rtl/fa36_pack.sv
module fa36_pack import fa36_pkg::*; (
  input  ufp_t              x_i,
  output logic [WORD_W-1:0] word_o,
  output logic              unf_o,
  output logic              big_o
);
  logic [WORD_W-1:0] mag;

  assign unf_o  = x_i.exp < $signed(XW'(0));
  assign big_o  = x_i.exp > $signed(XW'(EXP_MAX));
  assign mag    = {1'b0, x_i.exp[EXP_W-1:0], x_i.frac[NRM_B -: FRAC_W]};
  assign word_o = x_i.sgn ? -mag : mag;
endmodule

// File: rtl/fa36_adder.sv
module fa36_adder import fa36_pkg::*; (
  input  logic              clk,
  input  logic              rst,
  input  logic              vld_i,
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  input  logic              sub_i,
  input  logic              rnd_i,
  output logic [WORD_W-1:0] res_o,
  output logic              ovf_o,
  output logic              fov_o,
  output logic              unf_o,
  output logic              trap_o,
  output logic              vld_o
);
  logic [WORD_W-1:0] b_eff;
  logic [WORD_W-1:0] pass_w;
  logic              a_zero, b_zero;
  ufp_t              pass_uf, ua, ub, sum_uf, pre_uf, nr_uf;
  logic [WORD_W-1:0] packed_w;
  logic              pk_unf, pk_big, pk_rng;

  assign b_eff  = sub_i ? -b_i : b_i;
  assign a_zero = (a_i == '0);
  assign b_zero = (b_eff == '0);
  assign pass_w = a_zero ? b_eff : a_i;

  fa36_unpack #(.SIGNED_FRAC(1'b0)) u_pass (.word_i(pass_w), .uf_o(pass_uf));
  fa36_unpack #(.SIGNED_FRAC(1'b1)) u_ua   (.word_i(a_i),    .uf_o(ua));
  fa36_unpack #(.SIGNED_FRAC(1'b1)) u_ub   (.word_i(b_eff),  .uf_o(ub));

  fa36_align_add u_add (.ua_i(ua), .ub_i(ub), .sum_o(sum_uf));

  assign pre_uf = (a_zero || b_zero) ? pass_uf : sum_uf;

  fa36_norm_round u_nr (.x_i(pre_uf), .rnd_i(rnd_i), .y_o(nr_uf));

  fa36_pack u_pk (.x_i(nr_uf), .word_o(packed_w), .unf_o(pk_unf), .big_o(pk_big));

  assign pk_rng = pk_unf | pk_big;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o  <= '0;
      ovf_o  <= 1'b0;
      fov_o  <= 1'b0;
      unf_o  <= 1'b0;
      trap_o <= 1'b0;
      vld_o  <= 1'b0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) begin
        res_o  <= packed_w;
        ovf_o  <= pk_rng;
        fov_o  <= pk_rng;
        unf_o  <= pk_unf;
        trap_o <= pk_rng;
      end
    end
  end

  // R11
  vld_rise_chk: assert property (@(posedge clk) disable iff (rst) vld_i |=> vld_o);
  // R11
  vld_idle_chk: assert property (@(posedge clk) disable iff (rst) !vld_i |=> !vld_o);
  // R11
  res_hold_chk: assert property (@(posedge clk) disable iff (rst) !vld_i |=> $stable(res_o));
  // R3
  zero_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (vld_i && a_i == '0 && b_i == '0) |=> (res_o == '0 && !trap_o));
  // R7
  norm_lead_chk: assert property (@(posedge clk) disable iff (rst)
    (pre_uf.frac != '0) |-> nr_uf.frac[NRM_B]);
  // R7
  norm_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (pre_uf.frac == '0) |-> (nr_uf.exp == '0 && !nr_uf.sgn));
endmodule

// File: tb/sim_fa36_adder.sv
`timescale 1ns/1ps
module sim_fa36_adder;
  logic        clk = 1'b0;
  logic        rst;
  logic        vld_i;
  logic [35:0] a_i, b_i;
  logic        sub_i, rnd_i;
  logic [35:0] res_o;
  logic        ovf_o, fov_o, unf_o, trap_o, vld_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  fa36_adder u0 (
    .clk(clk), .rst(rst), .vld_i(vld_i), .a_i(a_i), .b_i(b_i),
    .sub_i(sub_i), .rnd_i(rnd_i), .res_o(res_o), .ovf_o(ovf_o),
    .fov_o(fov_o), .unf_o(unf_o), .trap_o(trap_o), .vld_o(vld_o)
  );

  task automatic check(input string tag, input logic [39:0] got, input logic [39:0] exp_v);
    checks++;
    if (got !== exp_v) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp_v);
    end
  endtask

  function automatic void ref_unpack(input logic [35:0] w, input bit twos,
                                     output bit s, output int e, output logic [63:0] f);
    s = w[35];
    e = int'(w[34:27]);
    f = {1'b0, w[26:0], 36'd0};
    if (s) begin
      e = e ^ 255;
      if (twos) begin
        if (f != 0) f[63] = 1'b1;
        else begin e = e + 1; f = 64'hC000_0000_0000_0000; end
      end else begin
        if (f != 0) begin f = -f; f[63] = 1'b0; end
        else begin e = e + 1; f = 64'h4000_0000_0000_0000; end
      end
    end
  endfunction

  // result {word, ovf, fov, unf, trap}
  function automatic logic [39:0] ref_add(input logic [35:0] a, input logic [35:0] b,
                                          input bit sub, input bit rnd);
    logic [35:0] bb, w;
    bit sa, sb, s, ts, lo, hi;
    int ea, eb, e, d, te;
    logic [63:0] fa, fb, f, tf;
    bb = sub ? (36'd0 - b) : b;
    if (a == 0 || bb == 0) begin
      ref_unpack((a == 0) ? bb : a, 1'b0, s, e, f);
    end else begin
      ref_unpack(a, 1'b1, sa, ea, fa);
      ref_unpack(bb, 1'b1, sb, eb, fb);
      if (eb > ea) begin
        ts = sa; sa = sb; sb = ts;
        te = ea; ea = eb; eb = te;
        tf = fa; fa = fb; fb = tf;
      end
      d = ea - eb;
      if (d > 63) d = 63;
      fb = 64'($signed(fb) >>> d);
      f = fa + fb;
      e = ea;
      if (sa != sb) begin
        if (f[63]) begin f = -f; s = 1'b1; end
        else s = 1'b0;
      end else begin
        s = sa;
        if (sa) f = -f;
        if (f[63]) begin f = f >> 1; e = e + 1; end
      end
    end
    if (f[63]) begin f = f >> 1; e = e + 1; end
    if (f == 0) return 40'd0;
    while (!f[62]) begin f = f << 1; e = e - 1; end
    if (rnd) begin
      f = f + 64'h0000_0008_0000_0000;
      if (f[63]) begin f = f >> 1; e = e + 1; end
    end
    lo = (e < 0);
    hi = (e > 255);
    w = {1'b0, 8'(e), f[62:36]};
    if (s) w = 36'd0 - w;
    return {w, lo | hi, lo | hi, lo, lo | hi};
  endfunction

  function automatic logic [39:0] outs();
    return {res_o, ovf_o, fov_o, unf_o, trap_o};
  endfunction

  task automatic drive(input logic [35:0] a, input logic [35:0] b, input bit sub, input bit rnd);
    @(negedge clk);
    a_i = a; b_i = b; sub_i = sub; rnd_i = rnd; vld_i = 1'b1;
    @(negedge clk);
    vld_i = 1'b0;
  endtask

  task automatic hand(input logic [35:0] a, input logic [35:0] b, input bit sub,
                      input bit rnd, input logic [39:0] exp_v, input string tag);
    drive(a, b, sub, rnd);
    check(tag, outs(), exp_v);
  endtask

  function automatic logic [35:0] pick_word();
    logic [35:0] w;
    int k;
    k = $urandom_range(0, 7);
    case (k)
      0: w = {4'($urandom), 32'($urandom)};
      1: w = 36'd0;
      2: w = {1'b0, 8'($urandom), 27'($urandom)};
      default: w = {1'b0, 8'(112 + $urandom_range(0, 31)), 1'b1, 26'($urandom)};
    endcase
    if (k != 0 && $urandom_range(0, 1) == 1) w = 36'd0 - w;
    return w;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R11 watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [35:0] ra, rb;
    logic [39:0] held;
    bit rs, rr;
    void'($urandom(32'h5EED_0A1D));
    rst = 1'b1; vld_i = 1'b0; a_i = '0; b_i = '0; sub_i = 1'b0; rnd_i = 1'b0;
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12 reset", {outs(), 0'b0}, 40'd0);
    if (vld_o !== 1'b0) begin checks++; fails++; $display("FAIL R12 vld: actual %b expected 0", vld_o); end
    else checks++;
    rst = 1'b0;

    // R6 like-sign carry, 1.0 + 1.0 = 2.0
    hand(36'h40C000000, 36'h40C000000, 1'b0, 1'b0, {36'h414000000, 4'b0000}, "R6 carry");
    // R2 subtract: 1.0 - (-1.0) = 2.0
    hand(36'h40C000000, 36'hBF4000000, 1'b1, 1'b0, {36'h414000000, 4'b0000}, "R2 sub neg");
    // R7 cancellation to zero
    hand(36'h40C000000, 36'h40C000000, 1'b1, 1'b1, {36'h000000000, 4'b0000}, "R7 zero");
    // R1 R6 negative result: 1.0 - 2.0 = -1.0
    hand(36'h40C000000, 36'h414000000, 1'b1, 1'b0, {36'hBF4000000, 4'b0000}, "R1 negative");
    // R4 negative zero-fraction word through pass path
    hand(36'hBF8000000, 36'h000000000, 1'b0, 1'b1, {36'hBF4000000, 4'b0000}, "R4 pass");
    // R4 same word through the summing path
    hand(36'hBF8000000, 36'h40C000000, 1'b0, 1'b0, {36'h000000000, 4'b0000}, "R4 sum");
    // R3 zero first operand, unnormalized second
    hand(36'h000000000, 36'h408000001, 1'b0, 1'b0, {36'h33C000000, 4'b0000}, "R3 pass");
    // R5 saturated shift of tiny negative operand
    hand(36'h40C000000, 36'hFFC000000, 1'b0, 1'b0, {36'h407FFFFFF, 4'b0000}, "R5 cap");
    hand(36'h40C000000, 36'hFFC000000, 1'b0, 1'b1, {36'h40C000000, 4'b0000}, "R5 cap rnd");
    // R8 rounding carry
    hand(36'h40FFFFFFF, 36'h334000000, 1'b0, 1'b1, {36'h414000000, 4'b0000}, "R8 round");
    hand(36'h40FFFFFFF, 36'h334000000, 1'b0, 1'b0, {36'h40FFFFFFF, 4'b0000}, "R8 trunc");
    // R9 underflow
    hand(36'h000000001, 36'h000000000, 1'b0, 1'b0, {36'h734000000, 4'b1111}, "R9 under");
    // R10 overflow
    hand(36'h7FFFFFFFF, 36'h7FFFFFFFF, 1'b0, 1'b0, {36'h007FFFFFF, 4'b1101}, "R10 over");

    // R11 latency and hold
    @(negedge clk);
    a_i = 36'h40C000000; b_i = 36'h40C000000; sub_i = 1'b0; rnd_i = 1'b0; vld_i = 1'b1;
    checks++;
    if (vld_o !== 1'b0) begin fails++; $display("FAIL R11 pre: actual %b expected 0", vld_o); end
    @(negedge clk);
    vld_i = 1'b0;
    checks++;
    if (vld_o !== 1'b1) begin fails++; $display("FAIL R11 strobe: actual %b expected 1", vld_o); end
    check("R11 latency", outs(), {36'h414000000, 4'b0000});
    held = outs();
    a_i = 36'h7FFFFFFFF; b_i = 36'h7FFFFFFFF;
    @(negedge clk);
    check("R11 hold", outs(), held);
    checks++;
    if (vld_o !== 1'b0) begin fails++; $display("FAIL R11 drop: actual %b expected 0", vld_o); end

    // R1 R5 R6 R7 R8 random mix against model
    for (int n = 0; n < 3000; n++) begin
      ra = pick_word();
      rb = pick_word();
      rs = 1'($urandom_range(0, 1));
      rr = 1'($urandom_range(0, 1));
      drive(ra, rb, rs, rr);
      check("R6 random", outs(), ref_add(ra, rb, rs, rr));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule